// File: doc/BRIEF.md
# Delayed-Branch Program Sequencer

This block produces the instruction fetch address for a small 8-bit controller core. Each cycle it receives the decoded control fields of the instruction held at the current fetch address. From these it advances sequentially, or it schedules a jump, call or return. A transfer always redirects fetch one instruction late: the instruction right after a transfer is a delay slot that executes whatever the condition gives. The address after that slot comes from the transfer's target.

Targets come in four forms. Two are short forms that use an 8-bit field alone, either as a signed offset or as a new low byte. Two are long forms that also take the upper address bits from a value the program loaded in advance. A condition may test the carry or zero flag. A call saves its return address on a private 16-entry stack that software cannot address. The stack raises sticky flags when a push finds it full or a pop finds it empty. Instruction memory and decode sit outside the block.

Top module: `dslot_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0, both stack flags are 0, and the return stack is empty.
- R2: An instruction with transfer kind 0 (none) that is not in a delay slot advances the fetch address by 1, modulo 4096.
- R3: Any transfer instruction (kind 1 jump, 2 call, 3 return) outside a delay slot is followed by its slot at address+1. The taken target is fetched in the cycle after the slot. A transfer that is not taken simply continues at slot+1.
- R4: Mode 0 (relative short) targets the transfer's own address plus the 8-bit field read as a signed value, modulo 4096.
- R5: Mode 1 (relative long) targets the transfer's own address plus the 12-bit value {high bits[3:0], field[7:0]}, modulo 4096.
- R6: Mode 2 (absolute short) targets {bits 11:8 of the transfer's own address, field}.
- R7: Mode 3 (absolute long) targets {high bits, field}.
- R8: Condition code 0 is always taken. Code 1 is taken when carry=1, code 2 when carry=0, code 3 when zero=1 and code 4 when zero=0. Codes 5 to 7 are never taken.
- R9: A taken call pushes the transfer's address + 2 (the instruction after its slot). A taken return redirects to the most recently pushed address and removes it. A return that is not taken leaves the stack unchanged.
- R10: A transfer that sits in a delay slot acts as a no-op: it causes no redirect, no push and no pop, and the instruction after it is fetched at address+1.
- R11: A push onto a stack that already holds 16 entries drops the oldest entry, keeps the newest 16 and sets the sticky overflow flag.
- R12: A taken return on an empty stack sets the sticky underflow flag, leaves the stack empty and targets address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opKind | input | 2 | Transfer kind of the instruction at fetchAddr: 0 none, 1 jump, 2 call, 3 return |
| addrMode | input | 2 | Target form: 0 rel short, 1 rel long, 2 abs short, 3 abs long |
| condSel | input | 3 | Condition code (see R8) |
| targetField | input | 8 | Short target field |
| hiBits | input | 4 | Preloaded upper address bits for long forms |
| carryFlag | input | 1 | Carry flag |
| zeroFlag | input | 1 | Zero flag |
| fetchAddr | output | 12 | Address of the instruction to fetch |
| stackOverflow | output | 1 | Sticky: a push found the stack full |
| stackUnderflow | output | 1 | Sticky: a return found the stack empty |

## Verification
The assertions assume that the decoded fields describe the instruction at the current fetch address and stay stable through each clock edge. They also assume that a single instruction never asks for a push and a pop at once. The opKind encoding makes the second point hold, and the bench drives every field from the falling edge, so the first holds as well. The bench feeds transfers inside delay slots, returns on an empty stack and more than 16 nested calls. These cases exercise the sticky flags and the slot-ignore rule, and none of them breaks the input assumptions.

// File: rtl/dslot_seq_pkg.sv
package dslot_seq_pkg;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_JUMP = 2'd1,
    XF_CALL = 2'd2,
    XF_RET  = 2'd3
  } xferKind_e;

  typedef enum logic [1:0] {
    TM_REL_SHORT = 2'd0,
    TM_REL_LONG  = 2'd1,
    TM_ABS_SHORT = 2'd2,
    TM_ABS_LONG  = 2'd3
  } tgtMode_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_CSET   = 3'd1,
    CC_CCLR   = 3'd2,
    CC_ZSET   = 3'd3,
    CC_ZCLR   = 3'd4
  } condCode_e;

  // strobes from control to datapath and stack
  typedef struct packed {
    logic armSlot;   // transfer accepted this cycle, latch its target
    logic jumpNow;   // this cycle is a slot of a taken transfer
    logic push;      // taken call
    logic pop;       // taken return
    logic useStack;  // target comes from the stack top
  } seqStrobe_t;

endpackage

// File: rtl/dslot_seq_ctrl.sv
module dslot_seq_ctrl
  import dslot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  xferKind_e  opKind,
  input  logic [2:0] condSel,
  input  logic       carryFlag,
  input  logic       zeroFlag,
  output seqStrobe_t stb
);

  logic inSlot;
  logic pendTaken;
  logic condOk;
  logic isXfer;
  logic taken;

  always_comb begin
    unique case (condSel)
      CC_ALWAYS: condOk = 1'b1;
      CC_CSET:   condOk = carryFlag;
      CC_CCLR:   condOk = !carryFlag;
      CC_ZSET:   condOk = zeroFlag;
      CC_ZCLR:   condOk = !zeroFlag;
      default:   condOk = 1'b0;
    endcase
  end

  always_comb begin
    isXfer       = (opKind != XF_NONE) && !inSlot;
    taken        = isXfer && condOk;
    stb.armSlot  = isXfer;
    stb.jumpNow  = inSlot && pendTaken;
    stb.push     = taken && (opKind == XF_CALL);
    stb.pop      = taken && (opKind == XF_RET);
    stb.useStack = (opKind == XF_RET);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inSlot    <= 1'b0;
      pendTaken <= 1'b0;
    end else begin
      inSlot    <= isXfer;
      pendTaken <= taken;
    end
  end

  // R8: codes above 4 never lead to a redirect after the slot
  a_r8_never_codes: assert property (@(posedge clk) disable iff (rst)
    (stb.armSlot && condSel > 3'd4) |=> !stb.jumpNow);

  // R10: a transfer sitting in a slot is never accepted again right after
  a_r10_slot_single: assert property (@(posedge clk) disable iff (rst)
    stb.armSlot |=> !stb.armSlot);

endmodule

// File: rtl/dslot_seq_stack.sv
module dslot_seq_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] topData,
  output logic              overflow,
  output logic              underflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrIdx;
  logic [PTR_W-1:0]  topIdx;
  logic [CNT_W-1:0]  count;
  logic              isEmpty;
  logic              isFull;

  always_comb begin
    isEmpty = (count == '0);
    isFull  = (count == FULL_CNT);
    topIdx  = (wrIdx == '0) ? LAST_IDX : wrIdx - PTR_W'(1);
    topData = isEmpty ? '0 : mem[topIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wrIdx     <= '0;
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (push) begin
      mem[wrIdx] <= pushData;
      wrIdx      <= (wrIdx == LAST_IDX) ? '0 : wrIdx + PTR_W'(1);
      if (isFull) overflow <= 1'b1;
      else        count    <= count + CNT_W'(1);
    end else if (pop) begin
      if (isEmpty) begin
        underflow <= 1'b1;
      end else begin
        wrIdx <= topIdx;
        count <= count - CNT_W'(1);
      end
    end
  end

  a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));

  // R9: last pushed value is visible on top next cycle
  a_r9_lifo_top: assert property (@(posedge clk) disable iff (rst)
    push |=> topData == $past(pushData));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  a_r11_full_push_flags: assert property (@(posedge clk) disable iff (rst)
    (push && isFull) |=> overflow && isFull);

  a_r12_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r12_empty_pop_stays: assert property (@(posedge clk) disable iff (rst)
    (pop && isEmpty) |=> underflow && isEmpty);

endmodule

// File: rtl/dslot_seq_dpath.sv
module dslot_seq_dpath
  import dslot_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         stb,
  input  tgtMode_e           addrMode,
  input  logic [FIELD_W-1:0] targetField,
  input  logic [ADDR_W-FIELD_W-1:0] hiBits,
  input  logic [ADDR_W-1:0]  stackTop,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [ADDR_W-1:0]  returnAddr
);

  localparam int HI_W = ADDR_W - FIELD_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] pendTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] nextTarget;
  logic [ADDR_W-1:0] shortOff;
  logic [ADDR_W-1:0] longVal;

  always_comb begin
    shortOff = {{HI_W{targetField[FIELD_W-1]}}, targetField};
    longVal  = {hiBits, targetField};
    unique case (addrMode)
      TM_REL_SHORT: jumpTarget = pc + shortOff;
      TM_REL_LONG:  jumpTarget = pc + longVal;
      TM_ABS_SHORT: jumpTarget = {pc[ADDR_W-1:FIELD_W], targetField};
      default:      jumpTarget = longVal;
    endcase
    nextTarget = stb.useStack ? stackTop : jumpTarget;
    returnAddr = pc + ADDR_W'(2);
    fetchAddr  = pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      pendTarget <= '0;
    end else begin
      pc <= stb.jumpNow ? pendTarget : pc + ADDR_W'(1);
      if (stb.armSlot) pendTarget <= nextTarget;
    end
  end

  // R3: the slot always follows the transfer
  a_r3_slot_follows: assert property (@(posedge clk) disable iff (rst)
    stb.armSlot |=> fetchAddr == $past(fetchAddr) + ADDR_W'(1));

  // R2: without a pending redirect, fetch is sequential
  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    !stb.jumpNow |=> fetchAddr == $past(fetchAddr) + ADDR_W'(1));

  // R6: absolute short keeps the upper bits of the transfer address
  a_r6_abs_short_page: assert property (@(posedge clk) disable iff (rst)
    (stb.armSlot && !stb.useStack && addrMode == TM_ABS_SHORT)
      |=> pendTarget[ADDR_W-1:FIELD_W] == $past(fetchAddr[ADDR_W-1:FIELD_W]));

endmodule

// File: rtl/dslot_sequencer.sv
module dslot_sequencer
  import dslot_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FIELD_W = 8,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         opKind,
  input  logic [1:0]         addrMode,
  input  logic [2:0]         condSel,
  input  logic [FIELD_W-1:0] targetField,
  input  logic [ADDR_W-FIELD_W-1:0] hiBits,
  input  logic               carryFlag,
  input  logic               zeroFlag,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic               stackOverflow,
  output logic               stackUnderflow
);

  seqStrobe_t        stb;
  logic [ADDR_W-1:0] stackTop;
  logic [ADDR_W-1:0] returnAddr;

  dslot_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opKind    (xferKind_e'(opKind)),
    .condSel   (condSel),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag),
    .stb       (stb)
  );

  dslot_seq_dpath #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .addrMode    (tgtMode_e'(addrMode)),
    .targetField (targetField),
    .hiBits      (hiBits),
    .stackTop    (stackTop),
    .fetchAddr   (fetchAddr),
    .returnAddr  (returnAddr)
  );

  dslot_seq_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (stb.push),
    .pop       (stb.pop),
    .pushData  (returnAddr),
    .topData   (stackTop),
    .overflow  (stackOverflow),
    .underflow (stackUnderflow)
  );

  // R1: flags are clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (fetchAddr == '0 && !stackOverflow && !stackUnderflow));

endmodule

// File: tb/dslot_sequencer_test.sv
module dslot_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opKind = '0;
  logic [1:0] addrMode = '0;
  logic [2:0] condSel = '0;
  logic [7:0] targetField = '0;
  logic [3:0] hiBits = '0;
  logic       carryFlag = 1'b0;
  logic       zeroFlag = 1'b0;
  logic [11:0] fetchAddr;
  logic       stackOverflow;
  logic       stackUnderflow;

  dslot_sequencer uut (
    .clk(clk), .rst(rst), .opKind(opKind), .addrMode(addrMode),
    .condSel(condSel), .targetField(targetField), .hiBits(hiBits),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .fetchAddr(fetchAddr),
    .stackOverflow(stackOverflow), .stackUnderflow(stackUnderflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int    mPc, mTarget;
  bit    mSlot, mTaken, mOvf, mUnf;
  string mTag, mChk;
  int    mStack[$];

  function automatic bit condEval(int c, bit cy, bit zr);
    case (c)
      0: return 1;
      1: return cy;
      2: return !cy;
      3: return zr;
      4: return !zr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      mPc = 0; mTarget = 0; mSlot = 0; mTaken = 0; mOvf = 0; mUnf = 0;
      mStack.delete(); mTag = "R1"; mChk = "R1";
    end else begin
      int  nPc;
      bit  isX, ok;
      int  f, h, tgt;
      string tg;
      nPc = (mSlot && mTaken) ? mTarget : (mPc + 1) % 4096;
      if (mSlot) mChk = mTaken ? mTag : ((opKind != 0) ? "R10" : "R3");
      else       mChk = (opKind != 0) ? "R3" : "R2";
      isX = (opKind != 0) && !mSlot;
      if (isX) begin
        ok = condEval(condSel, carryFlag, zeroFlag);
        f = targetField; h = hiBits;
        case (addrMode)
          0: begin tgt = (mPc + ((f >= 128) ? f - 256 : f) + 4096) % 4096; tg = "R4"; end
          1: begin tgt = (mPc + h * 256 + f) % 4096; tg = "R5"; end
          2: begin tgt = (mPc & 12'hF00) | f; tg = "R6"; end
          default: begin tgt = h * 256 + f; tg = "R7"; end
        endcase
        if (condSel != 0) tg = "R8";
        if (opKind == 2) begin
          tg = "R9";
          if (ok) begin
            if (mStack.size() == 16) begin void'(mStack.pop_front()); mOvf = 1; end
            mStack.push_back((mPc + 2) % 4096);
          end
        end else if (opKind == 3) begin
          tg = "R9";
          if (ok) begin
            if (mStack.size() == 0) begin tgt = 0; mUnf = 1; tg = "R12"; end
            else tgt = mStack.pop_back();
          end
        end
        mTarget = tgt; mTaken = ok; mTag = tg; mSlot = 1;
      end else begin
        mSlot = 0;
      end
      mPc = nPc;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (int'(fetchAddr) != mPc) begin
        fails++;
        $display("FAIL %s fetchAddr actual %0d expected %0d", mChk, fetchAddr, mPc);
      end
      vectors++;
      if (stackOverflow != mOvf) begin
        fails++;
        $display("FAIL R11 overflow actual %0d expected %0d", stackOverflow, mOvf);
      end
      vectors++;
      if (stackUnderflow != mUnf) begin
        fails++;
        $display("FAIL R12 underflow actual %0d expected %0d", stackUnderflow, mUnf);
      end
    end
  end

  task automatic step(input int op, input int md, input int cc, input int fld,
                      input int hi, input bit cy, input bit zr);
    @(negedge clk);
    opKind = 2'(op); addrMode = 2'(md); condSel = 3'(cc);
    targetField = 8'(fld); hiBits = 4'(hi); carryFlag = cy; zeroFlag = zr;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    nop(3);                       // R1 checked during and after reset
    rst = 0;
    nop(4);                       // R2
    step(1, 0, 0, 8'h10, 0, 0, 0); nop(3);   // R4 forward, R3 slot
    step(1, 0, 0, 8'hF0, 0, 0, 0); nop(3);   // R4 backward
    step(1, 1, 0, 8'h00, 1, 0, 0); nop(3);   // R5
    step(1, 1, 0, 8'h80, 4'hF, 0, 0); nop(3); // R5 wrap
    step(1, 2, 0, 8'h55, 0, 0, 0); nop(3);   // R6
    step(1, 3, 0, 8'h3C, 4'hA, 0, 0); nop(3); // R7
    for (int c = 0; c < 8; c++)
      for (int fl = 0; fl < 4; fl++) begin    // R8 every code, both flags
        step(1, 0, c, 8'h20, 0, fl[0], fl[1]); nop(2);
      end
    step(3, 0, 0, 0, 0, 0, 0); nop(3);       // R12 return on empty
    step(2, 3, 0, 8'h40, 2, 0, 0); nop(4);   // R9 call
    step(3, 0, 1, 0, 0, 0, 0); nop(2);       // R9 return not taken
    step(3, 0, 0, 0, 0, 0, 0); nop(3);       // R9 return taken
    step(1, 0, 0, 8'h30, 0, 0, 0);
    step(1, 3, 0, 8'h99, 7, 0, 0); nop(3);   // R10 jump in slot
    step(1, 0, 1, 8'h30, 0, 0, 0);
    step(2, 3, 0, 8'h99, 7, 0, 0); nop(3);   // R10 call in not-taken slot
    step(2, 2, 0, 8'h10, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 0); nop(3);       // R10 return in slot
    step(3, 0, 0, 0, 0, 0, 0); nop(3);
    for (int i = 0; i < 18; i++) begin       // R11 overflow
      step(2, 0, 0, 8'h08, 0, 0, 0); nop(2);
    end
    for (int i = 0; i < 18; i++) begin       // R11 newest 16 survive, then R12
      step(3, 0, 0, 0, 0, 0, 0); nop(2);
    end
    rst = 1; nop(2); rst = 0; nop(2);        // R1 flags cleared again
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      step((r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    nop(2);
    finishRun();
  end

endmodule